// File: doc/BRIEF.md
# Selectable Card Clock Divider

This block turns a reference clock into two derived clocks for a card interface. A host clock runs all the time at half the reference rate whenever the block is out of reset. A card clock is gated on and off by an enable from the activation sequencer. While it is enabled, it runs at either half or quarter of the reference rate. Two active-low commands pick the rate.

The enable and both commands pass through a synchronizer before the block acts on them. A new setting is taken up only while the card clock is low. It is also held back until the phase counter reaches the start of the new rate's low phase. As a result, the first pulse after enabling has full width, and no runt or extra pulse appears when the rate changes or the clock is stopped. All outputs are registered in the reference domain, so they have no combinational hazards.

Top module: `card_clk_divider`

## Requirements
- R1: After reset is released, `host_clk` inverts on every reference cycle, giving half the reference rate.
- R2: With `seq_en` high and only `fast_sel_n` low, once settled, `card_clk` equals `host_clk` on every cycle (half rate, same phase).
- R3: With `seq_en` high and only `slow_sel_n` low, once settled, `card_clk` is high for two cycles and low for two cycles (quarter rate), so each value is the inverse of the value two cycles earlier.
- R4: With `seq_en` high and both select commands low, the fast rate wins and `card_clk` behaves as in R2.
- R5: With `seq_en` low, or with both select commands high, `card_clk` settles low and stays low.
- R6: Every high pulse on `card_clk` lasts exactly one or exactly two reference cycles. Every two-cycle pulse is preceded by at least two low cycles. The rate or enable only changes while `card_clk` is low.
- R7: Each command passes through `SYNC_STAGES` flip-flops. Any new setting shows on `card_clk` within `SYNC_STAGES`+8 reference cycles.
- R8: While reset is asserted, `host_clk` and `card_clk` are both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| seq_en | input | 1 | Card clock enable from the activation sequencer, active high |
| fast_sel_n | input | 1 | Half-rate select command, active low |
| slow_sel_n | input | 1 | Quarter-rate select command, active low |
| host_clk | output | 1 | Free-running half-rate clock |
| card_clk | output | 1 | Gated card clock, half or quarter rate |

## Verification
The bench builds the block with `SYNC_STAGES` = 2. This keeps the synchronizer latency short enough that random hold times of one to four cycles often change the commands again before the previous setting has been taken up. That reaches the cases where a pending rate change is overtaken mid-alignment. Longer holds let the steady-state patterns for half rate, quarter rate, the fast-priority case and the off state be compared against the bench's own model of the expected rate. Pulse widths and the low time before each quarter-rate pulse are measured on every cycle, whether the setting is steady or changing.

// File: rtl/card_clk_pkg.sv
package card_clk_pkg;

  localparam int PH_W = 2;

  typedef enum logic [1:0] {
    RATE_OFF     = 2'd0,
    RATE_HALF    = 2'd1,
    RATE_QUARTER = 2'd2
  } rate_e;

  // Decode the synchronized commands; the fast select wins over the slow one.
  function automatic rate_e pick_rate(logic en, logic fast_n, logic slow_n);
    if (!en)          return RATE_OFF;
    else if (!fast_n) return RATE_HALF;
    else if (!slow_n) return RATE_QUARTER;
    else              return RATE_OFF;
  endfunction

  // Card clock level for a given rate at a given phase count.
  function automatic logic rate_level(rate_e r, logic [PH_W-1:0] ph);
    case (r)
      RATE_HALF:    return ph[0];
      RATE_QUARTER: return ph[1];
      default:      return 1'b0;
    endcase
  endfunction

  // True when the phase count sits on the first low cycle of the rate.
  function automatic logic low_start(rate_e r, logic [PH_W-1:0] ph);
    case (r)
      RATE_HALF:    return !ph[0];
      RATE_QUARTER: return ph == '0;
      default:      return 1'b1;
    endcase
  endfunction

endpackage

// File: rtl/ccd_sync.sv
module ccd_sync #(
  parameter int           STAGES  = 2,
  parameter int           W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  localparam int N = (STAGES < 1) ? 1 : STAGES;

  logic [N-1:0][W-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) chain[i] <= RST_VAL;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < N; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[N-1];

  // R7: the first stage captures the raw command one edge later
  a_r7_first_stage: assert property (@(posedge clk) disable iff (!rst_n)
    chain[0] == $past(d) || $past(!rst_n));

endmodule

// File: rtl/ccd_phase.sv
module ccd_phase
  import card_clk_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  output logic [PH_W-1:0] ph,
  output logic [PH_W-1:0] ph_nxt,
  output logic            host_clk
);

  logic run_q;

  assign ph_nxt = ph + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph    <= '0;
      run_q <= 1'b0;
    end else begin
      ph    <= ph_nxt;
      run_q <= 1'b1;
    end
  end

  assign host_clk = ph[0];

  // R1: host clock inverts on every reference edge once running
  a_r1_host_toggles: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> host_clk != $past(host_clk));

endmodule

// File: rtl/ccd_gate.sv
module ccd_gate
  import card_clk_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  rate_e           req,
  input  logic [PH_W-1:0] ph,
  input  logic [PH_W-1:0] ph_nxt,
  output logic            card_clk,
  output rate_e           mode,
  output logic            commit
);

  rate_e mode_q;
  rate_e eff;
  logic  card_q;
  logic  card_d;

  // A new rate is adopted only while the output is low and the phase count
  // is on the new rate's first low cycle.
  assign commit = !card_q && (req != mode_q) && low_start(req, ph);
  assign eff    = commit ? req : mode_q;
  assign card_d = rate_level(eff, ph_nxt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= RATE_OFF;
      card_q <= 1'b0;
    end else begin
      mode_q <= eff;
      card_q <= card_d;
    end
  end

  assign card_clk = card_q;
  assign mode     = mode_q;

  // R6: rate or enable changes happen only while the card clock is low
  a_r6_commit_low: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> !card_q);

  // R2: at half rate the card clock runs in phase with the host clock
  a_r2_half_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == RATE_HALF) |-> card_q == ph[0]);

  // R3: a quarter-rate high pulse lasts a second cycle
  a_r3_quarter_width: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == RATE_QUARTER && card_q && !$past(card_q)) |=> card_q);

  // R5: the card clock stays low while gated off
  a_r5_off_low: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == RATE_OFF) |-> !card_q);

endmodule

// File: rtl/card_clk_divider.sv
module card_clk_divider
  import card_clk_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic seq_en,
  input  logic fast_sel_n,
  input  logic slow_sel_n,
  output logic host_clk,
  output logic card_clk
);

  localparam int CMD_W = 3;

  logic [CMD_W-1:0] cmd_raw;
  logic [CMD_W-1:0] cmd_s;
  logic [PH_W-1:0]  ph;
  logic [PH_W-1:0]  ph_nxt;
  rate_e            req;
  rate_e            mode;
  logic             commit;

  assign cmd_raw = {seq_en, fast_sel_n, slow_sel_n};

  ccd_sync #(
    .STAGES  (SYNC_STAGES),
    .W       (CMD_W),
    .RST_VAL (3'b011)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (cmd_raw),
    .q     (cmd_s)
  );

  assign req = pick_rate(cmd_s[2], cmd_s[1], cmd_s[0]);

  ccd_phase u_phase (
    .clk      (clk),
    .rst_n    (rst_n),
    .ph       (ph),
    .ph_nxt   (ph_nxt),
    .host_clk (host_clk)
  );

  ccd_gate u_gate (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (req),
    .ph       (ph),
    .ph_nxt   (ph_nxt),
    .card_clk (card_clk),
    .mode     (mode),
    .commit   (commit)
  );

  // R6: a change of the active rate is always announced by a commit
  a_r6_mode_via_commit: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != $past(mode)) |-> $past(commit) || $past(!rst_n));

endmodule

// File: tb/sim_card_clk_divider.sv
`timescale 1ns/1ps
module sim_card_clk_divider;

  localparam int SYNC   = 2;
  localparam int SETTLE = SYNC + 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic fast_n = 1'b1;
  logic slow_n = 1'b1;
  wire  host;
  wire  card;

  always #2.5 clk = ~clk;

  card_clk_divider #(.SYNC_STAGES(SYNC)) u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .seq_en     (en),
    .fast_sel_n (fast_n),
    .slow_sel_n (slow_n),
    .host_clk   (host),
    .card_clk   (card)
  );

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;
  bit live = 1'b0;
  bit p_host = 1'b0;
  bit p_card = 1'b0;
  bit p2_card = 1'b0;
  int hi_run = 0;
  int lo_run = 100;
  int lo_before = 100;
  int since_chg = 0;

  task automatic chk(bit ok, string req, int act, int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // 0 = off, 1 = half, 2 = quarter
  function automatic int exp_rate(bit e, bit f_n, bit s_n);
    if (!e) return 0;
    if (!f_n) return 1;
    if (!s_n) return 2;
    return 0;
  endfunction

  task automatic step();
    @(negedge clk);
    if (live) chk(host != p_host, "R1 host toggle", host, !p_host);
    if (card && !p_card) begin
      lo_before = lo_run;
      hi_run = 1;
    end else if (card) begin
      hi_run++;
    end else if (p_card) begin
      chk(hi_run == 1 || hi_run == 2, "R6 high pulse width", hi_run, (hi_run > 2) ? 2 : 1);
      if (hi_run == 2) chk(lo_before >= 2, "R6 low time before quarter pulse", lo_before, 2);
      lo_run = 1;
    end else begin
      lo_run++;
    end
    if (live && since_chg >= SETTLE) begin
      case (exp_rate(en, fast_n, slow_n))
        0: chk(card == 1'b0, "R5 card clock held low", card, 0);
        1: chk(card == host, (!fast_n && !slow_n) ? "R4 fast priority" : "R2 half rate",
               card, host);
        default: chk(card == !p2_card, "R3 quarter rate", card, !p2_card);
      endcase
    end
    p2_card = p_card;
    p_card = card;
    p_host = host;
    since_chg++;
  endtask

  task automatic apply(bit e, bit f_n, bit s_n);
    if (e != en || f_n != fast_n || s_n != slow_n) since_chg = 0;
    en = e;
    fast_n = f_n;
    slow_n = s_n;
  endtask

  task automatic hold(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic first_pulse(bit f_n, bit s_n, string tag);
    int cnt;
    cnt = 0;
    apply(1'b1, f_n, s_n);
    while (!card && cnt < 40) begin
      step();
      cnt++;
    end
    chk(cnt <= SETTLE, tag, cnt, SETTLE);
  endtask

  initial begin
    void'($urandom(32'h5EED_0C1C));
    repeat (3) @(negedge clk);
    // R8: reset state
    chk(host == 1'b0, "R8 host low in reset", host, 0);
    chk(card == 1'b0, "R8 card low in reset", card, 0);
    rst_n = 1'b1;
    p_host = host;
    p_card = card;
    live = 1'b1;
    since_chg = 0;
    hold(12);
    // R7: enable at quarter rate from the off state
    first_pulse(1'b1, 1'b0, "R7 quarter start latency");
    hold(20);
    apply(1'b1, 1'b1, 1'b1);
    hold(16);
    // R7: enable at half rate from the off state
    first_pulse(1'b0, 1'b1, "R7 half start latency");
    hold(20);
    apply(1'b1, 1'b1, 1'b0);   // half -> quarter
    hold(24);
    apply(1'b1, 1'b0, 1'b0);   // both low: fast wins (R4)
    hold(24);
    apply(1'b0, 1'b0, 1'b0);   // sequencer enable off (R5)
    hold(20);
    apply(1'b1, 1'b1, 1'b0);
    hold(2);
    apply(1'b1, 1'b0, 1'b1);   // change before the first one settles
    hold(24);
    for (int seg = 0; seg < 400; seg++) begin
      int n;
      n = ($urandom % 4 == 0) ? 1 + int'($urandom % 4) : 12 + int'($urandom % 30);
      apply(($urandom % 5) != 0, $urandom % 2 == 1, $urandom % 2 == 1);
      hold(n);
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule